// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block converts a virtual address issued by a load, a store or an instruction fetch into a physical address. It uses a page table with one level that sits in physical memory. The virtual address has two parts: an upper page number and a lower page offset. The page number, added to a programmable table base, gives the byte address of one table entry. The block reads that entry through a simple memory read port. It then checks the valid bit and the access rights against the kind of request. The response carries either the physical address or a fault cause.

A page fault (the page is absent) and a protection fault (the page is present but the access is not allowed) are reported with different codes. Software gives each process its own table. It switches between processes by loading a new table base. If the base is loaded while a walk is in progress, the new value is held back until that walk has finished, so the walk in progress is not disturbed.

With the default parameters a page is 1 KB (10 offset bits). There are 32 virtual pages (a 15-bit virtual address) and 8 physical pages (a 13-bit physical address). A table entry is 8 bits wide.

Top module: `page_xlate`

## Requirements
- R1: While reset is held and right after it is released, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R2: In the cycle after a request is accepted, `mem_req_o` is 1 for exactly one cycle. In that cycle `mem_addr_o` equals (table base + virtual page number) modulo 2^13. The virtual page number is bits 14:10 of `req_vaddr_i`.
- R3: An entry is decoded as follows: bit 7 is the valid bit, bits 6:5 are the rights and bits 2:0 are the physical page number. If the valid bit is 1 and the access is allowed, the response has `rsp_fault_o` = 00 and `rsp_paddr_o` = {physical page number, vaddr[9:0]}. The offset passes through unchanged.
- R4: An entry whose valid bit is 0 gives `rsp_fault_o` = 01 (page fault), whatever its rights field holds.
- R5: The rights codes are: 00 read-only, 01 read/write, 10 execute-only, 11 read/write/execute. The access kinds are 00 load, 01 store, 10 fetch; code 11 is reserved. A load is allowed under rights 00, 01 and 11. A store is allowed under 01 and 11. A fetch is allowed under 10 and 11. A reserved kind is never allowed. A valid entry that does not allow the access gives `rsp_fault_o` = 10 (protection fault).
- R6: `rsp_paddr_o` is 0 on every faulting response.
- R7: Only one request is in flight at a time. `req_ready_o` is 0 from the acceptance edge until the edge at which the response is taken, and it is 1 again in the cycle after that.
- R8: Once raised, `rsp_valid_o`, `rsp_paddr_o` and `rsp_fault_o` stay stable until `rsp_ready_i` is seen high.
- R9: A base write made while the block is idle is used by the next translation.
- R10: A base write made while a translation is in flight is held and applied after the response has been taken. The walk in flight keeps the old base. If several writes arrive during one walk, the last one wins.
- R11: Memory read latency may vary. `rsp_valid_o` rises exactly one cycle after `mem_rvalid_i` is seen high while the block waits for the entry.
- R12: Entry bits 4:3 are reserved and have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Table base write strobe |
| base_i | input | 13 | New table base (physical byte address) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 15 | Virtual address |
| req_kind_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| mem_req_o | output | 1 | Entry read strobe, one cycle |
| mem_addr_o | output | 13 | Entry byte address |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 8 | Entry data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 13 | Physical address, 0 on a fault |
| rsp_fault_o | output | 2 | 00 none, 01 page fault, 10 protection fault |

## Verification
The bench builds the block with its default parameters: 10 offset bits, 5 page-number bits, 3 physical page bits and 8-bit entries. At this size every one of the 32 page numbers can be swept with all four access kinds under several table bases. One of those bases lies close enough to the top of the 13-bit space that the entry address wraps. The bench memory produces each entry from its address by arithmetic, so all rights codes, both valid states and nonzero reserved bits appear. Memory latency and response back-pressure vary from one request to the next, and base writes land during a walk, including two writes during the same walk.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RGT_RO  = 2'b00,
    RGT_RW  = 2'b01,
    RGT_X   = 2'b10,
    RGT_RWX = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10,
    ST_RESP  = 2'b11
  } walk_st_e;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [AW-1:0] base_o
);

  logic [AW-1:0] base_q, pend_val_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      pend_val_q <= '0;
      pend_q     <= 1'b0;
    end else if (!busy_i) begin
      // newest write beats a parked one
      if (we_i)        base_q <= wdata_i;
      else if (pend_q) base_q <= pend_val_q;
      pend_q <= 1'b0;
    end else if (we_i) begin
      pend_q     <= 1'b1;
      pend_val_q <= wdata_i;
    end
  end

  assign base_o = base_q;

  // R10
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> base_o == $past(base_o));

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import page_xlate_pkg::*;
(
  input  logic [1:0] rights_i,
  input  logic [1:0] kind_i,
  output logic       allow_o
);

  always_comb begin
    allow_o = 1'b0;
    unique case (acc_e'(kind_i))
      ACC_LOAD:  allow_o = (rights_e'(rights_i) != RGT_X);
      ACC_STORE: allow_o = (rights_e'(rights_i) == RGT_RW) || (rights_e'(rights_i) == RGT_RWX);
      ACC_FETCH: allow_o = (rights_e'(rights_i) == RGT_X)  || (rights_e'(rights_i) == RGT_RWX);
      ACC_RSVD:  allow_o = 1'b0;
    endcase
  end

  // R5
  perm_rsvd_chk: assert final ((kind_i != 2'b11) || !allow_o);

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import page_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 10,
  parameter int unsigned VPN_W = 5,
  parameter int unsigned PPN_W = 3,
  parameter int unsigned PTE_W = 8,
  localparam int unsigned VA_W = OFF_W + VPN_W,
  localparam int unsigned PA_W = OFF_W + PPN_W,
  localparam int unsigned V_BIT = PTE_W - 1,
  localparam int unsigned RGT_LSB = PTE_W - 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_kind_i,
  input  logic [PA_W-1:0]  base_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic [1:0]       rights_o,
  output logic [1:0]       kind_o,
  input  logic             allow_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_fault_o
);

  walk_st_e          st_q, st_d;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        kind_q;
  logic [PA_W-1:0]   paddr_q, paddr_d;
  logic [1:0]        fault_q, fault_d;
  logic              pte_vld;
  logic              take_req, take_pte;

  assign take_req = (st_q == ST_IDLE) && req_valid_i;
  assign take_pte = (st_q == ST_WAIT) && mem_rvalid_i;
  assign pte_vld  = mem_rdata_i[V_BIT];
  assign rights_o = mem_rdata_i[RGT_LSB +: 2];
  assign kind_o   = kind_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (mem_rvalid_i) st_d = ST_RESP;
      ST_RESP:  if (rsp_ready_i) st_d = ST_IDLE;
    endcase
  end

  // fault outranks any address
  always_comb begin
    if (!pte_vld) begin
      fault_d = FLT_PAGE;
      paddr_d = '0;
    end else if (!allow_i) begin
      fault_d = FLT_PROT;
      paddr_d = '0;
    end else begin
      fault_d = FLT_NONE;
      paddr_d = {mem_rdata_i[PPN_W-1:0], off_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      kind_q  <= '0;
      paddr_q <= '0;
      fault_q <= '0;
    end else begin
      st_q <= st_d;
      if (take_req) begin
        vpn_q  <= req_vaddr_i[VA_W-1:OFF_W];
        off_q  <= req_vaddr_i[OFF_W-1:0];
        kind_q <= req_kind_i;
      end
      if (take_pte) begin
        paddr_q <= paddr_d;
        fault_q <= fault_d;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign mem_req_o   = (st_q == ST_ISSUE);
  assign mem_addr_o  = base_i + PA_W'(vpn_q);
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;

  // R2
  mem_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R7
  one_inflight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !req_ready_o);

  // R8
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

  // R6
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_fault_o != 2'b00)) |-> (rsp_paddr_o == '0));

  // R11
  rsp_after_pte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_pte |=> rsp_valid_o);

  // R5
  fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o != 2'b11));

endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 10,
  parameter int unsigned VPN_W = 5,
  parameter int unsigned PPN_W = 3,
  parameter int unsigned PTE_W = 8,
  localparam int unsigned VA_W = OFF_W + VPN_W,
  localparam int unsigned PA_W = OFF_W + PPN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_kind_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_fault_o
);

  logic [PA_W-1:0] base;
  logic            busy, allow;
  logic [1:0]      rights, kind;

  pt_base_reg #(.AW(PA_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_i),
    .busy_i  (busy),
    .base_o  (base)
  );

  pt_perm_check u_perm (
    .rights_i (rights),
    .kind_i   (kind),
    .allow_o  (allow)
  );

  pt_walk_ctrl #(
    .OFF_W (OFF_W),
    .VPN_W (VPN_W),
    .PPN_W (PPN_W),
    .PTE_W (PTE_W)
  ) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_vaddr_i  (req_vaddr_i),
    .req_kind_i   (req_kind_i),
    .base_i       (base),
    .busy_o       (busy),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .rights_o     (rights),
    .kind_o       (kind),
    .allow_i      (allow),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_fault_o  (rsp_fault_o)
  );

endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [12:0] base_wd = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        mem_req;
  logic [12:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [12:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_fail = 0;
  logic [12:0] cur_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .base_we_i    (base_we),
    .base_i       (base_wd),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_vaddr_i  (req_vaddr),
    .req_kind_i   (req_kind),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .rsp_valid_o  (rsp_valid),
    .rsp_ready_i  (rsp_ready),
    .rsp_paddr_o  (rsp_paddr),
    .rsp_fault_o  (rsp_fault)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // table contents derived from entry address
  function automatic logic [7:0] pte_of(input logic [12:0] a);
    return 8'((32'(a) * 37 + 11) ^ (32'(a) >> 3));
  endfunction

  function automatic bit allowed(input logic [1:0] r, input logic [1:0] k);
    case (k)
      2'd0: return r != 2'd2;
      2'd1: return r == 2'd1 || r == 2'd3;
      2'd2: return r == 2'd2 || r == 2'd3;
      default: return 1'b0;
    endcase
  endfunction

  task automatic write_base(input logic [12:0] v);
    @(negedge clk);
    base_we = 1'b1; base_wd = v;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = v;
  endtask

  // mode: 0 no write, 1 one write in flight, 2 two writes in flight
  task automatic xlate(input logic [14:0] va, input logic [1:0] kind,
                       input int lat, input int hold, input int mode,
                       input logic [12:0] wv);
    logic [12:0] ea, exp_pa;
    logic [7:0]  pte;
    logic [1:0]  exp_f;
    logic [12:0] pa0;
    logic [1:0]  f0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    ea = cur_base + 13'(va[14:10]);
    chk(req_ready == 1'b0, "R7 busy", int'(req_ready), 0);
    chk(mem_req == 1'b1, "R2 strobe", int'(mem_req), 1);
    chk(mem_addr == ea, "R2 addr", int'(mem_addr), int'(ea));
    if (mode > 0) begin
      base_we = 1'b1;
      base_wd = (mode == 2) ? (wv ^ 13'h155) : wv;
    end
    @(negedge clk);
    base_we = 1'b0;
    for (int i = 0; i < lat; i++) begin
      chk(mem_req == 1'b0, "R2 single", int'(mem_req), 0);
      chk(rsp_valid == 1'b0, "R11 early", int'(rsp_valid), 0);
      @(negedge clk);
    end
    pte = pte_of(ea);
    mem_rvalid = 1'b1; mem_rdata = pte;
    if (mode == 2) begin
      base_we = 1'b1; base_wd = wv;
    end
    @(negedge clk);
    mem_rvalid = 1'b0; base_we = 1'b0;
    if (!pte[7]) begin
      exp_f = 2'b01; exp_pa = '0;
    end else if (!allowed(pte[6:5], kind)) begin
      exp_f = 2'b10; exp_pa = '0;
    end else begin
      exp_f = 2'b00; exp_pa = {pte[2:0], va[9:0]};
    end
    chk(rsp_valid == 1'b1, "R11 rsp", int'(rsp_valid), 1);
    if (pte[7])
      chk(rsp_fault == exp_f, "R5 fault (R12)", int'(rsp_fault), int'(exp_f));
    else
      chk(rsp_fault == exp_f, "R4 fault", int'(rsp_fault), int'(exp_f));
    if (exp_f == 2'b00)
      chk(rsp_paddr == exp_pa, "R3 paddr (R12)", int'(rsp_paddr), int'(exp_pa));
    else
      chk(rsp_paddr == exp_pa, "R6 zero", int'(rsp_paddr), 0);
    pa0 = rsp_paddr; f0 = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa0 && rsp_fault == f0, "R8 hold",
          int'(rsp_paddr), int'(pa0));
      chk(req_ready == 1'b0, "R7 resp", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R8 drop", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R7 reopen", int'(req_ready), 1);
    if (mode > 0) cur_base = wv;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [12:0] bases [3];
    bases[0] = 13'h0000; bases[1] = 13'h0A37; bases[2] = 13'h1FF0;
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp", int'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1 mem", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !rsp_valid && !mem_req, "R1 post", int'(req_ready), 1);

    for (int b = 0; b < 3; b++) begin
      write_base(bases[b]); // R9
      for (int v = 0; v < 32; v++) begin
        for (int k = 0; k < 4; k++) begin
          logic [9:0] off;
          off = (v % 5 == 0) ? 10'h3FF : ((v % 5 == 1) ? 10'h000 : 10'(v * 97 + k * 311));
          xlate({5'(v), off}, 2'(k), (v + k) % 3, (v ^ k) & 1, 0, '0);
        end
      end
    end

    // R10 deferral, single then double write in flight
    write_base(13'h0100);
    xlate(15'h0C21, 2'd0, 1, 1, 1, 13'h0800);
    xlate(15'h0C21, 2'd0, 0, 0, 0, '0);
    xlate(15'h7ABC, 2'd1, 2, 2, 2, 13'h1234);
    xlate(15'h7ABC, 2'd2, 1, 0, 0, '0);
    xlate(15'h0000, 2'd3, 0, 1, 1, 13'h1FFF);
    xlate(15'h0400, 2'd0, 2, 0, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule